// File: doc/BRIEF.md
# Concurrent Multi-Lane Calibration Sequencer

This block runs the calibration of a group of serial sensor lanes. Every lane has its own training controller, and all lanes are trained at the same time rather than one after another. A start command puts the sensor into training mode. The sequencer then moves every lane through three phases in a fixed order: bit alignment, word alignment and lane (channel) alignment. Each phase opens with one start pulse, which goes to all lane controllers together. The phase closes only when every lane reports that it has finished, so each phase acts as a barrier across the lanes.

When the last phase closes, the block pulses a completion flag. It also reports an overall pass status, which is the AND of the per-lane pass flags, and it keeps a copy of the per-lane flags for debug. A cycle-count watchdog with a limit set at run time aborts any phase that takes too long, and this clears the pass status. Start commands that arrive while a calibration is running are dropped.

Top module: `lane_cal_sequencer`

## Requirements
- R1: After reset, every output is low, and `phase_o` is 0. The phase encoding is 0 idle, 1 bit alignment, 2 word alignment, 3 channel alignment.
- R2: `start_i` sampled high while idle starts a calibration. In the next cycle `train_mode_o` is high, `bit_start_o` is high, `phase_o` is 1, and `all_ok_o` and `timeout_o` are low.
- R3: Each phase start pulse lasts exactly one cycle. At most one of the three start pulses is high in any cycle, and they are issued in the order bit, word, channel.
- R4: A phase ends at the first edge where every lane's done bit for that phase is high at once. The next phase's pulse, or completion, appears in the following cycle. If only some lanes are done, nothing happens.
- R5: Done bits that are high during the cycle of the phase's own start pulse do not count toward that phase.
- R6: When the channel phase ends, `done_o` is high for exactly one cycle and `train_mode_o` and `phase_o` return to 0. In that cycle `all_ok_o` equals the AND of `lane_ok_i` sampled at the closing edge, and `lane_ok_o` holds that sample.
- R7: `all_ok_o`, `timeout_o` and `lane_ok_o` keep their values after a run ends, until the next accepted start.
- R8: Let cycle 0 be the cycle of a phase's start pulse. A barrier met in cycles 1 to `wdog_limit_i` is accepted. If the barrier is still unmet at the end of cycle `wdog_limit_i`, the run aborts: in the next cycle `done_o` and `timeout_o` are high, `all_ok_o` is low, `train_mode_o` is low and `lane_ok_o` holds `lane_ok_i`.
- R9: `start_i` has no effect while `train_mode_o` is high. No bit-alignment pulse is issued and the phase does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin calibration |
| wdog_limit_i | input | TMO_W | Maximum cycles allowed per phase (1 or more) |
| lane_bit_done_i | input | NUM_LANES | Per-lane bit alignment finished |
| lane_word_done_i | input | NUM_LANES | Per-lane word alignment finished |
| lane_chan_done_i | input | NUM_LANES | Per-lane channel alignment finished |
| lane_ok_i | input | NUM_LANES | Per-lane calibration pass flag |
| train_mode_o | output | 1 | Training pattern request toward the sensor |
| bit_start_o | output | 1 | Broadcast bit-alignment start pulse |
| word_start_o | output | 1 | Broadcast word-alignment start pulse |
| chan_start_o | output | 1 | Broadcast channel-alignment start pulse |
| phase_o | output | 2 | Current phase (0 idle, 1 bit, 2 word, 3 channel) |
| done_o | output | 1 | One-cycle end-of-run flag |
| all_ok_o | output | 1 | Every lane passed, held until next start |
| timeout_o | output | 1 | Run aborted by watchdog, held until next start |
| lane_ok_o | output | NUM_LANES | Per-lane pass flags captured at end of run |

## Verification
The bench holds the done bits of all lanes but one high for several cycles, and it changes which lane is missing. A sequencer that OR-reduced the flags, or that checked a single lane, would move on early. It drives done bits during the start-pulse cycle itself, which catches a design that accepts flags left over from the previous phase. It probes the watchdog exactly at the limit and one cycle past it, so an off-by-one in the counter shows up as a spurious abort or a missed one. It also pulses start in the middle of a run, which exposes a design that restarts and re-issues the bit-alignment pulse.

// File: rtl/lcs_pkg.sv
`timescale 1ns/1ps
package lcs_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_BIT  = 2'd1,
      PH_WORD = 2'd2,
      PH_CHAN = 2'd3
   } phase_e;
endpackage

// File: rtl/lcs_barrier.sv
`timescale 1ns/1ps
// Cross-lane barrier: picks the done vector of the active phase and reduces it.
module lcs_barrier #(
   parameter int NUM_LANES = 8
) (
   input  lcs_pkg::phase_e       phase_i,
   input  logic [NUM_LANES-1:0]  bit_done_i,
   input  logic [NUM_LANES-1:0]  word_done_i,
   input  logic [NUM_LANES-1:0]  chan_done_i,
   output logic                  met_o
);
   import lcs_pkg::*;

   logic [NUM_LANES-1:0] sel_done;

   always_comb begin
      unique case (phase_i)
         PH_BIT:  sel_done = bit_done_i;
         PH_WORD: sel_done = word_done_i;
         PH_CHAN: sel_done = chan_done_i;
         default: sel_done = '0;
      endcase
   end

   generate
      if (NUM_LANES == 1) begin : g_single
         assign met_o = sel_done[0] && (phase_i != PH_IDLE);
      end else begin : g_multi
         assign met_o = (&sel_done) && (phase_i != PH_IDLE);
      end
   endgenerate
endmodule

// File: rtl/lcs_watchdog.sv
`timescale 1ns/1ps
// Per-phase cycle counter; saturates at its maximum value.
module lcs_watchdog #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expired_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (run_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/lcs_lane_snapshot.sv
`timescale 1ns/1ps
// Per-lane capture of the pass flags at the end of a run.
module lcs_lane_snapshot #(
   parameter int NUM_LANES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture_i,
   input  logic [NUM_LANES-1:0] lane_ok_i,
   output logic [NUM_LANES-1:0] lane_ok_o
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_LANES; gi++) begin : g_lane
         logic ok_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         ok_q <= 1'b0;
            else if (capture_i) ok_q <= lane_ok_i[gi];
         end
         assign lane_ok_o[gi] = ok_q;
      end
   endgenerate
endmodule

// File: rtl/lane_cal_sequencer.sv
`timescale 1ns/1ps
module lane_cal_sequencer #(
   parameter int NUM_LANES = 8,
   parameter int TMO_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [TMO_W-1:0]     wdog_limit_i,
   input  logic [NUM_LANES-1:0] lane_bit_done_i,
   input  logic [NUM_LANES-1:0] lane_word_done_i,
   input  logic [NUM_LANES-1:0] lane_chan_done_i,
   input  logic [NUM_LANES-1:0] lane_ok_i,
   output logic                 train_mode_o,
   output logic                 bit_start_o,
   output logic                 word_start_o,
   output logic                 chan_start_o,
   output logic [1:0]           phase_o,
   output logic                 done_o,
   output logic                 all_ok_o,
   output logic                 timeout_o,
   output logic [NUM_LANES-1:0] lane_ok_o
);
   import lcs_pkg::*;

   generate
      if (NUM_LANES < 1) begin : g_bad_lanes
         $error("lane_cal_sequencer: NUM_LANES must be at least 1");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("lane_cal_sequencer: TMO_W must be at least 2");
      end
   endgenerate

   phase_e phase_q;
   logic   pulse_q;
   logic   train_q;
   logic   done_q;
   logic   all_ok_q;
   logic   tmo_q;

   logic   barrier_met;
   logic   wdog_expired;
   logic   waiting;
   logic   launch_bit;
   logic   advance;
   logic   finish;
   logic   abort;

   lcs_barrier #(.NUM_LANES(NUM_LANES)) u_barrier (
      .phase_i     (phase_q),
      .bit_done_i  (lane_bit_done_i),
      .word_done_i (lane_word_done_i),
      .chan_done_i (lane_chan_done_i),
      .met_o       (barrier_met)
   );

   // Flags present during the start-pulse cycle are not counted.
   assign waiting    = (phase_q != PH_IDLE) && !pulse_q;
   assign launch_bit = (phase_q == PH_IDLE) && start_i;
   assign advance    = waiting && barrier_met && (phase_q != PH_CHAN);
   assign finish     = waiting && barrier_met && (phase_q == PH_CHAN);
   assign abort      = waiting && !barrier_met && wdog_expired;

   lcs_watchdog #(.CNT_W(TMO_W)) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (launch_bit || advance),
      .run_i     (phase_q != PH_IDLE),
      .limit_i   (wdog_limit_i),
      .expired_o (wdog_expired)
   );

   lcs_lane_snapshot #(.NUM_LANES(NUM_LANES)) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (finish || abort),
      .lane_ok_i (lane_ok_i),
      .lane_ok_o (lane_ok_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         pulse_q  <= 1'b0;
         train_q  <= 1'b0;
         done_q   <= 1'b0;
         all_ok_q <= 1'b0;
         tmo_q    <= 1'b0;
      end else begin
         pulse_q <= launch_bit || advance;
         done_q  <= finish || abort;
         if (launch_bit) begin
            phase_q  <= PH_BIT;
            train_q  <= 1'b1;
            all_ok_q <= 1'b0;
            tmo_q    <= 1'b0;
         end else if (advance) begin
            phase_q <= phase_e'(phase_q + 2'd1);
         end else if (finish) begin
            phase_q  <= PH_IDLE;
            train_q  <= 1'b0;
            all_ok_q <= &lane_ok_i;
         end else if (abort) begin
            phase_q  <= PH_IDLE;
            train_q  <= 1'b0;
            all_ok_q <= 1'b0;
            tmo_q    <= 1'b1;
         end
      end
   end

   assign train_mode_o = train_q;
   assign bit_start_o  = pulse_q && (phase_q == PH_BIT);
   assign word_start_o = pulse_q && (phase_q == PH_WORD);
   assign chan_start_o = pulse_q && (phase_q == PH_CHAN);
   assign phase_o      = phase_q;
   assign done_o       = done_q;
   assign all_ok_o     = all_ok_q;
   assign timeout_o    = tmo_q;
endmodule

// File: rtl/lane_cal_sequencer_chk.sv
`timescale 1ns/1ps
module lcs_checker #(
   parameter int NUM_LANES = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic [NUM_LANES-1:0] lane_bit_done_i,
   input logic [NUM_LANES-1:0] lane_word_done_i,
   input logic                 train_mode_o,
   input logic                 bit_start_o,
   input logic                 word_start_o,
   input logic                 chan_start_o,
   input logic                 done_o,
   input logic                 all_ok_o,
   input logic                 timeout_o,
   input logic [NUM_LANES-1:0] lane_ok_o
);
   assert_pulse_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bit_start_o, word_start_o, chan_start_o}));

   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_start_o || word_start_o || chan_start_o) |=>
      !(bit_start_o || word_start_o || chan_start_o));

   assert_train_opens_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(train_mode_o) |-> bit_start_o);

   assert_word_after_barrier_R4: assert property (@(posedge clk) disable iff (!rst_n)
      word_start_o |-> $past(&lane_bit_done_i));

   assert_chan_after_barrier_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chan_start_o |-> $past(&lane_word_done_i));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_all_ok_matches_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !timeout_o) |-> (all_ok_o == (&lane_ok_o)));

   assert_timeout_clears_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> !all_ok_o);

   assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (train_mode_o && start_i) |=> !bit_start_o);
endmodule

bind lane_cal_sequencer lcs_checker #(.NUM_LANES(NUM_LANES)) u_lcs_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .start_i          (start_i),
   .lane_bit_done_i  (lane_bit_done_i),
   .lane_word_done_i (lane_word_done_i),
   .train_mode_o     (train_mode_o),
   .bit_start_o      (bit_start_o),
   .word_start_o     (word_start_o),
   .chan_start_o     (chan_start_o),
   .done_o           (done_o),
   .all_ok_o         (all_ok_o),
   .timeout_o        (timeout_o),
   .lane_ok_o        (lane_ok_o)
);

// File: tb/lane_cal_sequencer_tb_top.sv
`timescale 1ns/1ps
module lane_cal_sequencer_tb_top;
   localparam int NL = 8;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [TW-1:0] wdog_limit_i = 16'd8;
   logic [NL-1:0] dn [3];
   logic [NL-1:0] lane_ok_i = '0;
   logic          train_mode_o, bit_start_o, word_start_o, chan_start_o;
   logic [1:0]    phase_o;
   logic          done_o, all_ok_o, timeout_o;
   logic [NL-1:0] lane_ok_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   lane_cal_sequencer #(.NUM_LANES(NL), .TMO_W(TW)) dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .start_i          (start_i),
      .wdog_limit_i     (wdog_limit_i),
      .lane_bit_done_i  (dn[0]),
      .lane_word_done_i (dn[1]),
      .lane_chan_done_i (dn[2]),
      .lane_ok_i        (lane_ok_i),
      .train_mode_o     (train_mode_o),
      .bit_start_o      (bit_start_o),
      .word_start_o     (word_start_o),
      .chan_start_o     (chan_start_o),
      .phase_o          (phase_o),
      .done_o           (done_o),
      .all_ok_o         (all_ok_o),
      .timeout_o        (timeout_o),
      .lane_ok_o        (lane_ok_o)
   );

   // {lane_ok, k_bit, k_word, k_chan, limit, poke_start}
   localparam logic [47:0] VEC [7] = '{
      {8'hFF, 8'd1, 8'd1, 8'd1, 8'd4, 8'd0},
      {8'hFF, 8'd3, 8'd5, 8'd2, 8'd5, 8'd1},
      {8'hFE, 8'd2, 8'd2, 8'd2, 8'd4, 8'd0},
      {8'h5A, 8'd1, 8'd4, 8'd3, 8'd6, 8'd1},
      {8'hFF, 8'd2, 8'd7, 8'd1, 8'd6, 8'd0},
      {8'hFF, 8'd2, 8'd2, 8'd9, 8'd8, 8'd0},
      {8'hFF, 8'd4, 8'd3, 8'd6, 8'd6, 8'd0}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Called at the negedge of the pulse cycle of phase 'which'.
   task automatic do_phase(input int which, input int k, input int lim,
                           input bit poke, input logic [NL-1:0] ok, output bit aborted);
      aborted = 1'b0;
      for (int c = 1; c < 1000; c++) begin
         @(negedge clk);
         if (poke && c == 2) begin
            start_i = 1'b0;
            chk("R9", "bit pulse after busy start", int'(bit_start_o), 0);
            chk("R9", "phase after busy start", int'(phase_o), which + 1);
         end
         if (k > lim && c == lim + 1) begin
            chk("R8", "abort done", int'(done_o), 1);
            chk("R8", "abort timeout", int'(timeout_o), 1);
            chk("R8", "abort all_ok", int'(all_ok_o), 0);
            chk("R8", "abort train", int'(train_mode_o), 0);
            chk("R8", "abort lane_ok", int'(lane_ok_o), int'(ok));
            aborted = 1'b1;
            break;
         end
         if (c == k + 1) break;
         chk("R4", "still in phase", int'(phase_o), which + 1);
         chk("R3", "pulse dropped", int'(bit_start_o | word_start_o | chan_start_o), 0);
         if (poke && c == 1) start_i = 1'b1;
         if (c == k) dn[which] = '1;
         else        dn[which] = ~(8'h01 << (c % NL));
      end
   endtask

   task automatic run_cal(input logic [NL-1:0] ok, input int kb, input int kw,
                          input int kc, input int lim, input bit poke);
      int  ks [3];
      bit  ab;
      int  exp_ok;
      ks[0] = kb; ks[1] = kw; ks[2] = kc;
      lane_ok_i    = ok;
      wdog_limit_i = TW'(lim);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R2", "bit pulse", int'(bit_start_o), 1);
      chk("R2", "train mode", int'(train_mode_o), 1);
      chk("R2", "phase", int'(phase_o), 1);
      chk("R2", "all_ok cleared", int'(all_ok_o), 0);
      chk("R2", "timeout cleared", int'(timeout_o), 0);
      ab = 1'b0;
      for (int p = 0; p < 3; p++) begin
         do_phase(p, ks[p], lim, poke && (p == 1), ok, ab);
         dn[p] = '0;
         if (ab) break;
         if (p == 0) begin
            chk("R4", "word pulse after barrier", int'(word_start_o), 1);
            chk("R3", "phase word", int'(phase_o), 2);
         end else if (p == 1) begin
            chk("R4", "chan pulse after barrier", int'(chan_start_o), 1);
            chk("R3", "phase chan", int'(phase_o), 3);
         end
      end
      if (!ab) begin
         chk("R6", "done", int'(done_o), 1);
         chk("R6", "train low", int'(train_mode_o), 0);
         chk("R6", "phase idle", int'(phase_o), 0);
         chk("R6", "all_ok", int'(all_ok_o), int'(ok == 8'hFF));
         chk("R6", "lane_ok", int'(lane_ok_o), int'(ok));
         chk("R6", "no timeout", int'(timeout_o), 0);
      end
      exp_ok = (!ab && ok == 8'hFF) ? 1 : 0;
      lane_ok_i = ~ok;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (i == 0) chk("R6", "done one cycle", int'(done_o), 0);
         chk("R7", "all_ok held", int'(all_ok_o), exp_ok);
         chk("R7", "timeout held", int'(timeout_o), int'(ab));
         chk("R7", "lane_ok held", int'(lane_ok_o), int'(ok));
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start_i = 1'b0;
      dn[0] = '0; dn[1] = '0; dn[2] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic check_reset_state();
      chk("R1", "train", int'(train_mode_o), 0);
      chk("R1", "pulses", int'(bit_start_o | word_start_o | chan_start_o), 0);
      chk("R1", "phase", int'(phase_o), 0);
      chk("R1", "done", int'(done_o), 0);
      chk("R1", "all_ok", int'(all_ok_o), 0);
      chk("R1", "timeout", int'(timeout_o), 0);
      chk("R1", "lane_ok", int'(lane_ok_o), 0);
   endtask

   initial begin
      dn[0] = '0; dn[1] = '0; dn[2] = '0;
      do_reset();
      @(negedge clk);
      check_reset_state();

      for (int v = 0; v < 7; v++) begin
         run_cal(VEC[v][47:40], int'(VEC[v][39:32]), int'(VEC[v][31:24]),
                 int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][0]);
      end

      // R5: done flags during the pulse cycle are not counted
      lane_ok_i = 8'hFF;
      wdog_limit_i = 16'd8;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R5", "bit pulse", int'(bit_start_o), 1);
      dn[0] = '1;
      @(negedge clk);
      dn[0] = '0;
      chk("R5", "no word pulse from stale flags", int'(word_start_o), 0);
      chk("R5", "still bit phase", int'(phase_o), 1);
      @(negedge clk);
      dn[0] = '1;
      @(negedge clk);
      dn[0] = '0;
      chk("R4", "word pulse after real barrier", int'(word_start_o), 1);

      // R1: reset mid-run returns to idle
      do_reset();
      @(negedge clk);
      check_reset_state();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule